// File: doc/BRIEF.md
# Memory-Mapped Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output for a processor. Software reaches it through a small 32-bit register bus. The bus is word addressed, has a write strobe and a read strobe, and returns read data one cycle after the read strobe. Each input is captured into a status bit. A per-input parameter mask picks how that capture works: a 1 makes the input react to a rising edge, and a 0 makes it react to a high level.

A status bit counts as pending only while its enable bit is also set. Software can change the enables in three ways: a full write, an OR-in alias that sets bits, and a clear alias that removes bits. Neither alias disturbs the enable bits that are written as zero. Software retires a request by writing ones to the acknowledge register. The vector register names the lowest-numbered pending input, and reads as all ones when nothing is pending. A two-bit master register gates the processor interrupt, and both of its bits must be set before the output can assert.

Top module: `irq_hub`

## Requirements
- R1: After reset the status, enable and master registers are zero and `irq_out` is low. Every register reads zero, except the vector register, which reads 0xFFFFFFFF.
- R2: The word addresses are: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. `bus_rdata` carries the addressed register in the cycle after `bus_rd` is high, and is 0 in any other cycle. Addresses 3, 4 and 5 always read 0. Writes to addresses 0, 1 and 6 have no effect.
- R3: A level-kind input (kind bit 0) sets its status bit on every cycle it is high. If the bit is acknowledged while the input is still high, the bit is set again one cycle later. Once the input is low, an acknowledge clears the bit for good.
- R4: An edge-kind input (kind bit 1) sets its status bit on a rising edge only. The bit stays set after the input falls. An input that stays high does not set the bit again after an acknowledge.
- R5: A write to acknowledge clears each status bit written as 1 and leaves the other bits alone. If an acknowledge and a capture fall in the same cycle, the acknowledge wins. Writing 0xFFFFFFFF clears every status bit.
- R6: A write to enable replaces the whole enable register. Writing 0 to it disables every input.
- R7: Set-enable ORs the written ones into the enable register, and clear-enable clears the enable bits written as 1. All other enable bits keep their values.
- R8: Pending reads as status AND enable.
- R9: The vector register reads the index of the lowest-numbered pending input. It reads 0xFFFFFFFF when no input is pending.
- R10: Master bit 0 is the master enable and bit 1 is the hardware enable. Both bits read back, and the bits above them read 0. `irq_out` is high exactly when some input is pending and both master bits are 1.
- R11: Kind-mask bits at or above `N_IN` have no effect. Enable bits at or above `N_IN` do not exist and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IN | Interrupt request lines |
| bus_addr | input | 3 | Word address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Interrupt to the processor |

## Verification
The bench acknowledges a level input while it is still high and expects the bit to return. A design that let the acknowledge win permanently would lose the request. It acknowledges a held edge input and expects the bit to stay clear, which would fail if the edge detector rearmed on level. It raises an edge in the very cycle of its own acknowledge, and expects the request to be dropped rather than surviving. It also checks that each master bit alone keeps the output low, that the lowest pending index wins when two inputs compete, and that enable bits beyond the input count read 0.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [DW-1:0] NO_VECTOR = '1;

  typedef enum logic [AW-1:0] {
    REG_STAT  = 3'd0,
    REG_PEND  = 3'd1,
    REG_EN    = 3'd2,
    REG_ACK   = 3'd3,
    REG_SETEN = 3'd4,
    REG_CLREN = 3'd5,
    REG_VEC   = 3'd6,
    REG_MSTR  = 3'd7
  } reg_sel_e;

  // returns {found, index} of the lowest set bit
  function automatic logic [5:0] lowest_index(input logic [DW-1:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, 5'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_hub_capture.sv
module irq_hub_capture #(
  parameter int          N_IN      = 8,
  parameter logic [31:0] KIND_MASK = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_i,
  input  logic [N_IN-1:0] ack_i,
  output logic [N_IN-1:0] hit_o,
  output logic [N_IN-1:0] status_o
);
  logic [N_IN-1:0] status_q;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    if (KIND_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= irq_i[i];
      end
      assign hit_o[i] = irq_i[i] & ~prev_q;
    end else begin : g_level
      assign hit_o[i] = irq_i[i];
      // R3
      level_recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i[i] && !ack_i[i]) |=> status_q[i]);
    end
    // R5
    ack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i[i] |=> !status_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q | hit_o) & ~ack_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  reg_sel_e        sel_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [N_IN-1:0] enable_o,
  output logic [1:0]      master_o,
  output logic [N_IN-1:0] ack_o
);
  logic [N_IN-1:0] en_q;
  logic [1:0]      mstr_q;
  logic [N_IN-1:0] wbits;

  assign wbits = wdata_i[N_IN-1:0];

  if (N_IN < DW) begin : g_spare
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata_i[DW-1:N_IN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mstr_q <= '0;
    end else if (wr_i) begin
      case (sel_i)
        REG_EN:    en_q   <= wbits;
        REG_SETEN: en_q   <= en_q | wbits;
        REG_CLREN: en_q   <= en_q & ~wbits;
        REG_MSTR:  mstr_q <= wdata_i[1:0];
        default:   ;
      endcase
    end
  end

  assign ack_o    = (wr_i && sel_i == REG_ACK) ? wbits : '0;
  assign enable_o = en_q;
  assign master_o = mstr_q;

  // R7
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == REG_SETEN) |=> ((en_q & $past(wbits)) == $past(wbits)));
  // R7
  clr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == REG_CLREN) |=> ((en_q & $past(wbits)) == '0));
  // R6
  en_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && sel_i == REG_EN && wbits == '0) |=> (en_q == '0));
endmodule

// File: rtl/irq_hub_vector.sv
module irq_hub_vector
  import irq_hub_pkg::*;
#(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0] pend_i,
  output logic [DW-1:0]   vec_o,
  output logic            any_o
);
  logic [5:0] pick;

  assign pick  = lowest_index(DW'(pend_i));
  assign any_o = pick[5];
  assign vec_o = pick[5] ? DW'(pick[4:0]) : NO_VECTOR;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int          N_IN      = 8,
  parameter logic [31:0] KIND_MASK = 32'hFFFF_00F0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_in,
  input  logic [2:0]      bus_addr,
  input  logic            bus_wr,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_rd,
  output logic [31:0]     bus_rdata,
  output logic            irq_out
);
  reg_sel_e        sel;
  logic [N_IN-1:0] ack_vec;
  logic [N_IN-1:0] hit_vec;
  logic [N_IN-1:0] status;
  logic [N_IN-1:0] enable;
  logic [N_IN-1:0] pending;
  logic [1:0]      master;
  logic [DW-1:0]   vector;
  logic            any_pend;
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   rdata_q;

  assign sel = reg_sel_e'(bus_addr);

  irq_hub_capture #(.N_IN(N_IN), .KIND_MASK(KIND_MASK)) u_capture (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .ack_i(ack_vec),
    .hit_o(hit_vec), .status_o(status)
  );

  irq_hub_ctrl #(.N_IN(N_IN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .sel_i(sel), .wdata_i(bus_wdata),
    .enable_o(enable), .master_o(master), .ack_o(ack_vec)
  );

  assign pending = status & enable;

  irq_hub_vector #(.N_IN(N_IN)) u_vector (
    .pend_i(pending), .vec_o(vector), .any_o(any_pend)
  );

  logic unused_hits;
  assign unused_hits = ^hit_vec;

  always_comb begin
    case (sel)
      REG_STAT: rd_mux = DW'(status);
      REG_PEND: rd_mux = DW'(pending);
      REG_EN:   rd_mux = DW'(enable);
      REG_VEC:  rd_mux = vector;
      REG_MSTR: rd_mux = DW'(master);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = any_pend & (master == 2'b11);

  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));
  // R9
  empty_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == '0) |-> (vector == NO_VECTOR));
  // R10
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == REG_MSTR && bus_wdata[1:0] != 2'b11) |=> !irq_out);
  // R8
  enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq_out);
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          irq_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_hub #(.N_IN(N), .KIND_MASK(32'hFFFF_00F0)) u_irq_hub (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read data one cycle after the strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R2 unexpected read", bus_rdata, 32'h0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    check(tag, 32'(irq_out), 32'(exp));
  endtask

  task automatic drive(input int i, input logic v);
    @(negedge clk);
    irq_in[i] = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq(1'b0, "R1 irq_out");
    rd(3'd0, 32'h0, "R1 status");
    rd(3'd1, 32'h0, "R1 pending");
    rd(3'd2, 32'h0, "R1 enable");
    rd(3'd3, 32'h0, "R1 ack");
    rd(3'd4, 32'h0, "R1 seten");
    rd(3'd5, 32'h0, "R1 clren");
    rd(3'd6, 32'hFFFF_FFFF, "R1 vector");
    rd(3'd7, 32'h0, "R1 master");
    @(negedge clk); check("R2 idle rdata", bus_rdata, 32'h0);
    // R10 master read-back
    wr(3'd7, 32'h3);          rd(3'd7, 32'h3, "R10 master");
    wr(3'd7, 32'hFFFF_FFFF);  rd(3'd7, 32'h3, "R10 master upper");
    // R11 enable width, R6 full write
    wr(3'd2, 32'hFFFF_FFFF);  rd(3'd2, 32'hFF, "R11 enable width");
    wr(3'd2, 32'h0);          rd(3'd2, 32'h0, "R6 enable zero");
    wr(3'd2, 32'h0A);         rd(3'd2, 32'h0A, "R6 enable write");
    // R7 aliases
    wr(3'd4, 32'h05);         rd(3'd2, 32'h0F, "R7 set-enable");
    wr(3'd5, 32'h03);         rd(3'd2, 32'h0C, "R7 clear-enable");
    rd(3'd4, 32'h0, "R2 seten reads 0");
    // R3 level capture on input 2
    drive(2, 1'b1);
    rd(3'd0, 32'h04, "R3 level set");
    rd(3'd1, 32'h04, "R8 pending");
    rd(3'd6, 32'd2, "R9 vector");
    chk_irq(1'b1, "R10 irq_out on");
    wr(3'd3, 32'h04);         rd(3'd0, 32'h04, "R3 level re-set");
    drive(2, 1'b0);
    wr(3'd3, 32'h04);         rd(3'd0, 32'h0, "R3 level cleared");
    chk_irq(1'b0, "R10 irq_out off");
    // R4 edge capture on input 5
    drive(5, 1'b1); drive(5, 1'b0);
    rd(3'd0, 32'h20, "R4 edge held");
    rd(3'd1, 32'h0, "R8 masked pending");
    rd(3'd6, 32'hFFFF_FFFF, "R9 none pending");
    chk_irq(1'b0, "R8 masked irq");
    wr(3'd4, 32'h20);
    rd(3'd6, 32'd5, "R9 vector 5");
    drive(6, 1'b1);
    rd(3'd0, 32'h60, "R4 edge 6");
    wr(3'd3, 32'h40);         rd(3'd0, 32'h20, "R4 steady high no re-set / R5 others kept");
    drive(3, 1'b1);
    rd(3'd1, 32'h28, "R8 pending two");
    rd(3'd6, 32'd3, "R9 lowest wins");
    // R10 gating by each master bit
    wr(3'd7, 32'h1);          chk_irq(1'b0, "R10 master bit0 only");
    wr(3'd7, 32'h2);          chk_irq(1'b0, "R10 master bit1 only");
    wr(3'd7, 32'h3);          chk_irq(1'b1, "R10 both bits");
    // R5 acknowledge beats a same-cycle edge on input 7
    @(negedge clk);
    irq_in[7] = 1'b1; bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = 32'h80;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(3'd0, 32'h28, "R5 ack wins");
    // R2 writes to read-only registers ignored
    wr(3'd0, 32'hFF);         rd(3'd0, 32'h28, "R2 status write ignored");
    wr(3'd6, 32'h0);          rd(3'd6, 32'd3, "R2 vector write ignored");
    // R5 acknowledge all
    @(negedge clk); irq_in = '0;
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R5 ack all");
    rd(3'd6, 32'hFFFF_FFFF, "R9 empty after ack");
    chk_irq(1'b0, "R5 irq after ack all");
    // R6 zero enable blocks everything
    wr(3'd2, 32'h0);
    drive(0, 1'b1);
    rd(3'd0, 32'h01, "R6 status still captured");
    rd(3'd1, 32'h0, "R6 nothing pending");
    chk_irq(1'b0, "R6 irq low");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule